// File: doc/BRIEF.md
# Script Memory-Move Copy Engine

This block executes the memory-to-memory copy instruction of a small script processor. The instruction arrives as three 32-bit words on a valid/ready stream. The first word holds an operation code, a flag that suppresses the prefetch flush, and a 24-bit byte count. The second word is the source address and the third is the destination address. Once all three words are in, the engine checks the instruction. If it is legal, it may first ask the instruction prefetch unit to flush and then waits for that unit to acknowledge. It then copies the bytes one at a time over a byte-wide memory bus that uses a request/acknowledge handshake.

Any address whose upper bits match the chip's configured register base falls in a 128-byte register window. Such an access is redirected to an internal register file and never reaches the bus. This lets a script save registers to memory and restore them later. One register in the window cannot be written by a copy.

On the instruction stream, a word transfers on a rising edge where `ins_valid` and `ins_ready` are both high. The engine lowers `ins_ready` while it executes, which applies back-pressure to the instruction source. The memory bus is back-pressured by `mem_ack`: a request stays up, with its fields stable, until it is acknowledged.

Top module: `mmove_engine`

## Requirements
- R1: After reset, `ins_ready` is high and `mem_req`, `flush_req`, `done` and `illegal` are low. The three instruction words are accepted in order, each on an edge where `ins_valid` and `ins_ready` are both high. The first word is laid out as follows: bits [31:29] are the operation code, which must be 3'b110; bit 24 is the no-flush flag; bits [23:0] are the byte count. The second word is the source address and the third word is the destination address.
- R2: An instruction is illegal if its operation code is not 3'b110, or if bits [1:0] of the source and destination addresses differ. An illegal instruction produces a one-cycle `illegal` pulse with no bus access, no flush and no `done`.
- R3: When `pf_enable` is 1 and the no-flush flag is 0, a one-cycle `flush_req` pulse is issued before any bus access. No bus access starts until `flush_ack` has been seen high.
- R4: When the no-flush flag is 1, or when `pf_enable` is 0, no flush request is issued.
- R5: Byte i of the transfer is read from source+i and then written to destination+i, for i rising from 0. Each byte that goes to or from memory uses exactly one bus transaction.
- R6: A byte count of zero ends the instruction with a `done` pulse and no bus access. The flush rule of R3 still applies.
- R7: `done` is a one-cycle pulse that follows completion of the last byte's write.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` and `mem_we` stay stable. During a write, `mem_wdata` also stays stable.
- R9: An address whose bits [31:7] equal `reg_base[31:7]` accesses internal register number addr[6:0] and never appears on the bus. A copy from the window returns the bytes that earlier copies stored there; registers reset to 0.
- R10: Register 8 of the window cannot be written by a copy. It keeps its value, which is 0 after reset, while the neighbouring registers in the same copy are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction word valid |
| ins_ready | output | 1 | Engine can accept an instruction word |
| ins_data | input | 32 | Instruction word |
| pf_enable | input | 1 | Global prefetch enable; the no-flush flag matters only when this is 1 |
| reg_base | input | 32 | Register window base; bits [31:7] are compared |
| flush_req | output | 1 | One-cycle request to flush the prefetch unit |
| flush_ack | input | 1 | Prefetch unit has flushed |
| mem_req | output | 1 | Bus request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Bus acknowledge |
| done | output | 1 | One-cycle pulse: copy finished |
| illegal | output | 1 | One-cycle pulse: instruction rejected |

## Verification
The bench targets several corner cases, each paired here with the failure a wrong design would show:
- A zero byte count: a wrong design would run a 16-million-byte loop or touch the bus once.
- A misaligned pair of addresses: a wrong design would copy anyway, or flush before rejecting the instruction.
- Flush gating: the bench drives all combinations of the enable and the flag, so a design that ignores the enable or inverts the flag shows up as an extra or missing flush.
- Flush ordering: a flush that arrives after the first bus access is caught.
- The register window: a copy in and back out through the window exposes any redirect that leaks onto the bus or reads the wrong register.
- The protected register: a copy that spans it shows the register changing when it should stay put.
- Bus wait states: acknowledges that arrive late expose a request that drops or whose address moves before it is acknowledged.

// File: rtl/mmove_pkg.sv
package mmove_pkg;
  localparam logic [2:0] OP_MOVE = 3'b110;

  typedef enum logic [3:0] {
    S_W0, S_W1, S_W2, S_CHK, S_FLUSH, S_FWAIT, S_RD, S_WR, S_DONE, S_ERR
  } mm_state_e;
endpackage

// File: rtl/mmove_win_dec.sv
// Register-window decode: an address hits when its upper bits equal the base.
module mmove_win_dec #(
  parameter int AW = 32,
  parameter int IW = 7
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = (addr[AW-1:IW] == base[AW-1:IW]);
    idx = addr[IW-1:0];
  end
endmodule

// File: rtl/mmove_regfile.sv
// Internal register file reachable through the window; one entry is write-protected.
module mmove_regfile #(
  parameter int IW   = 7,
  parameter int DW   = 8,
  parameter int PROT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NREG = 1 << IW;

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == PROT) begin : g_ro
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[g] <= '0;
        else        regs[g] <= regs[g];
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            regs[g] <= '0;
        else if (we && (waddr == IW'(g)))      regs[g] <= wdata;
      end
    end
  end

  always_comb rdata = regs[raddr];
endmodule

// File: rtl/mmove_seq.sv
// Instruction latch, legality check, flush control and byte-copy sequencing.
module mmove_seq
  import mmove_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 8,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [31:0]   ins_data,
  input  logic          pf_enable,
  output logic          flush_req,
  input  logic          flush_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          done,
  output logic          illegal,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  input  logic          src_hit,
  input  logic          dst_hit,
  input  logic [IW-1:0] dst_idx,
  output logic          rf_we,
  output logic [IW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata
);
  localparam int NF_BIT = CW;

  mm_state_e     st_q;
  logic [2:0]    op_q;
  logic          nf_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] data_q;
  logic          rd_step, wr_step, bad;

  always_comb begin
    bad     = (op_q != OP_MOVE) || (src_q[1:0] != dst_q[1:0]);
    rd_step = (st_q == S_RD) && (src_hit || mem_ack);
    wr_step = (st_q == S_WR) && (dst_hit || mem_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_W0;
      op_q   <= '0;
      nf_q   <= 1'b0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        S_W0: if (ins_valid) begin
          cnt_q <= ins_data[CW-1:0];
          nf_q  <= ins_data[NF_BIT];
          op_q  <= ins_data[31:29];
          st_q  <= S_W1;
        end
        S_W1: if (ins_valid) begin
          src_q <= AW'(ins_data);
          st_q  <= S_W2;
        end
        S_W2: if (ins_valid) begin
          dst_q <= AW'(ins_data);
          st_q  <= S_CHK;
        end
        S_CHK: begin
          if (bad)                      st_q <= S_ERR;
          else if (pf_enable && !nf_q)  st_q <= S_FLUSH;
          else if (cnt_q == '0)         st_q <= S_DONE;
          else                          st_q <= S_RD;
        end
        S_FLUSH: st_q <= S_FWAIT;
        S_FWAIT: if (flush_ack) st_q <= (cnt_q == '0) ? S_DONE : S_RD;
        S_RD: if (rd_step) begin
          data_q <= src_hit ? rf_rdata : mem_rdata;
          st_q   <= S_WR;
        end
        S_WR: if (wr_step) begin
          src_q <= src_q + AW'(1);
          dst_q <= dst_q + AW'(1);
          cnt_q <= cnt_q - CW'(1);
          st_q  <= (cnt_q == CW'(1)) ? S_DONE : S_RD;
        end
        S_DONE: st_q <= S_W0;
        S_ERR:  st_q <= S_W0;
        default: st_q <= S_W0;
      endcase
    end
  end

  always_comb begin
    ins_ready = (st_q == S_W0) || (st_q == S_W1) || (st_q == S_W2);
    flush_req = (st_q == S_FLUSH);
    done      = (st_q == S_DONE);
    illegal   = (st_q == S_ERR);
    mem_req   = ((st_q == S_RD) && !src_hit) || ((st_q == S_WR) && !dst_hit);
    mem_we    = (st_q == S_WR);
    mem_addr  = (st_q == S_WR) ? dst_q : src_q;
    mem_wdata = data_q;
    rf_we     = (st_q == S_WR) && dst_hit;
    rf_waddr  = dst_idx;
    rf_wdata  = data_q;
    src_addr  = src_q;
    dst_addr  = dst_q;
  end
endmodule

// File: rtl/mmove_engine.sv
// Top: sequencer, two window decoders and the internal register file.
module mmove_engine #(
  parameter int AW   = 32,
  parameter int CW   = 24,
  parameter int DW   = 8,
  parameter int IW   = 7,
  parameter int PROT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [31:0]   ins_data,
  input  logic          pf_enable,
  input  logic [AW-1:0] reg_base,
  output logic          flush_req,
  input  logic          flush_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          done,
  output logic          illegal
);
  logic [AW-1:0] src_addr, dst_addr;
  logic          src_hit, dst_hit;
  logic [IW-1:0] src_idx, dst_idx;
  logic          rf_we;
  logic [IW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, rf_rdata;

  mmove_win_dec #(.AW(AW), .IW(IW)) u_dec_src (
    .addr(src_addr), .base(reg_base), .hit(src_hit), .idx(src_idx)
  );
  mmove_win_dec #(.AW(AW), .IW(IW)) u_dec_dst (
    .addr(dst_addr), .base(reg_base), .hit(dst_hit), .idx(dst_idx)
  );

  mmove_regfile #(.IW(IW), .DW(DW), .PROT(PROT)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
    .wdata(rf_wdata), .raddr(src_idx), .rdata(rf_rdata)
  );

  mmove_seq #(.AW(AW), .CW(CW), .DW(DW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data),
    .pf_enable(pf_enable), .flush_req(flush_req), .flush_ack(flush_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done), .illegal(illegal),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .src_hit(src_hit), .dst_hit(dst_hit), .dst_idx(dst_idx),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata)
  );
endmodule

// File: rtl/mmove_engine_chk.sv
module mmove_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 8,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_ready,
  input logic [AW-1:0] reg_base,
  input logic          flush_req,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          done,
  input logic          illegal
);
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> (!mem_req && !flush_req && !done));

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !mem_req && !flush_req));

  p_flush_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  p_flush_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !mem_req);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_wdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

  p_no_window_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[AW-1:IW] != reg_base[AW-1:IW]));
endmodule

bind mmove_engine mmove_engine_chk #(.AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .reg_base(reg_base),
  .flush_req(flush_req), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .done(done), .illegal(illegal)
);

// File: tb/mmove_engine_test.sv
module mmove_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_data = '0;
  logic        pf_enable = 1'b0;
  logic [31:0] reg_base = 32'h0000_8000;
  logic        flush_req;
  logic        flush_ack = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        done, illegal;

  int errors = 0, checks = 0;
  int lat = 0;
  int wait_cnt = 0;
  int n_bus = 0, n_rd = 0, n_wr = 0, n_flush = 0, flush_late = 0, win_bus = 0;
  logic [7:0] bmem [4096];
  bit finished = 0;

  always #10 clk = ~clk;

  mmove_engine uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .pf_enable(pf_enable), .reg_base(reg_base),
    .flush_req(flush_req), .flush_ack(flush_ack), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done(done), .illegal(illegal)
  );

  // memory responder
  initial forever begin
    @(negedge clk);
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (wait_cnt < lat) wait_cnt++;
      else begin
        wait_cnt = 0;
        mem_ack = 1'b1;
        n_bus++;
        if (mem_addr[31:7] == reg_base[31:7]) win_bus++;
        if (mem_we) begin n_wr++; bmem[mem_addr[11:0]] = mem_wdata; end
        else begin n_rd++; mem_rdata = bmem[mem_addr[11:0]]; end
      end
    end
  end

  // prefetch unit model
  initial forever begin
    @(negedge clk);
    flush_ack = 1'b0;
    if (rst_n && flush_req) begin
      n_flush++;
      if (n_bus != 0) flush_late++;
      repeat (2) @(negedge clk);
      flush_ack = 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_bus = 0; n_rd = 0; n_wr = 0; n_flush = 0; flush_late = 0; win_bus = 0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_data  = w;
    while (!ins_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // issue a move and wait for done or illegal
  task automatic run_move(input logic [2:0] op, input bit nf, input int cnt,
                          input logic [31:0] src, input logic [31:0] dst,
                          output int got_done, output int got_ill);
    clear_counts();
    send({op, 4'b0, nf, cnt[23:0]});
    send(src);
    send(dst);
    @(negedge clk);
    ins_valid = 1'b0;
    got_done = 0; got_ill = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) got_done++;
      if (illegal) got_ill++;
      if (done || illegal) break;
      @(negedge clk);
    end
    @(negedge clk);
    if (done) got_done++;
    if (illegal) got_ill++;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) ^ 8'h5A);
  endfunction

  task automatic t_reset();
    chk("R1 ins_ready after reset", int'(ins_ready), 1);
    chk("R1 mem_req after reset", int'(mem_req), 0);
    chk("R1 flush_req after reset", int'(flush_req), 0);
    chk("R1 done/illegal after reset", int'(done | illegal), 0);
  endtask

  task automatic t_basic_copy();
    int d, e, bad;
    lat = 2; pf_enable = 1'b1;
    run_move(3'b110, 1'b1, 5, 32'h101, 32'h205, d, e);
    bad = 0;
    for (int i = 0; i < 5; i++) if (bmem[12'h205 + i] != pat(12'h101 + i)) bad++;
    chk("R5 bytes copied", bad, 0);
    chk("R5 bus transactions", n_bus, 10);
    chk("R4 no flush when flag set", n_flush, 0);
    chk("R7 single done pulse", d, 1);
    chk("R8 byte after end untouched", int'(bmem[12'h20A]), int'(pat(12'h20A)));
  endtask

  task automatic t_flush_copy();
    int d, e, bad;
    lat = 1; pf_enable = 1'b1;
    run_move(3'b110, 1'b0, 3, 32'h122, 32'h332, d, e);
    bad = 0;
    for (int i = 0; i < 3; i++) if (bmem[12'h332 + i] != pat(12'h122 + i)) bad++;
    chk("R3 flush issued once", n_flush, 1);
    chk("R3 flush before bus", flush_late, 0);
    chk("R3 copy after flush", bad, 0);
    chk("R7 done after flush copy", d, 1);
  endtask

  task automatic t_flush_disabled();
    int d, e;
    lat = 0; pf_enable = 1'b0;
    run_move(3'b110, 1'b0, 2, 32'h140, 32'h3C0, d, e);
    chk("R4 no flush when enable low", n_flush, 0);
    chk("R4 copy done", int'(bmem[12'h3C1]), int'(pat(12'h141)));
  endtask

  task automatic t_zero_count();
    int d, e;
    pf_enable = 1'b1;
    run_move(3'b110, 1'b0, 0, 32'h150, 32'h450, d, e);
    chk("R6 zero count done", d, 1);
    chk("R6 zero count no bus", n_bus, 0);
    chk("R6 zero count still flushes", n_flush, 1);
  endtask

  task automatic t_illegal();
    int d, e;
    pf_enable = 1'b1;
    run_move(3'b110, 1'b0, 4, 32'h160, 32'h461, d, e);
    chk("R2 misaligned illegal pulse", e, 1);
    chk("R2 misaligned no done", d, 0);
    chk("R2 misaligned no bus", n_bus, 0);
    chk("R2 misaligned no flush", n_flush, 0);
    run_move(3'b010, 1'b1, 4, 32'h160, 32'h460, d, e);
    chk("R2 bad opcode illegal", e, 1);
    chk("R2 bad opcode no bus", n_bus, 0);
  endtask

  task automatic t_window();
    int d, e, bad;
    pf_enable = 1'b0; lat = 1;
    run_move(3'b110, 1'b1, 4, 32'h300, 32'h8010, d, e);
    chk("R9 write to window uses only bus reads", n_wr, 0);
    chk("R9 window not on bus", win_bus, 0);
    chk("R9 reads counted", n_rd, 4);
    run_move(3'b110, 1'b1, 4, 32'h8010, 32'h600, d, e);
    bad = 0;
    for (int i = 0; i < 4; i++) if (bmem[12'h600 + i] != pat(12'h300 + i)) bad++;
    chk("R9 window readback", bad, 0);
    chk("R9 readback only bus writes", n_rd, 0);
  endtask

  task automatic t_protected();
    int d, e;
    pf_enable = 1'b0; lat = 0;
    run_move(3'b110, 1'b1, 4, 32'h704, 32'h8008, d, e);
    run_move(3'b110, 1'b1, 4, 32'h8008, 32'h800, d, e);
    chk("R10 protected register unchanged", int'(bmem[12'h800]), 0);
    chk("R10 neighbour written", int'(bmem[12'h801]), int'(pat(12'h705)));
    chk("R10 last neighbour written", int'(bmem[12'h803]), int'(pat(12'h707)));
  endtask

  task automatic t_long_copy();
    int d, e, bad;
    pf_enable = 1'b1; lat = 0;
    run_move(3'b110, 1'b0, 20, 32'h903, 32'hA07, d, e);
    bad = 0;
    for (int i = 0; i < 20; i++) if (bmem[12'hA07 + i] != pat(12'h903 + i)) bad++;
    chk("R5 20-byte copy", bad, 0);
    chk("R5 20-byte bus count", n_bus, 40);
    chk("R7 done for long copy", d, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_copy();
    t_flush_copy();
    t_flush_disabled();
    t_zero_count();
    t_illegal();
    t_window();
    t_protected();
    t_long_copy();
    finish_run();
  end
endmodule